// File: doc/BRIEF.md
# Strap-Addressed Indexed Register Target for a Two-Wire Management Bus

This block is an SMBus target that holds a nine-byte configuration and identification file for a clock buffer. The host writes a run of bytes starting at an index. To read, the host sets an index, issues a repeated start and clocks bytes back. The target always answers a read with a length byte first. The length comes from a writable count field.

The 7-bit bus address is picked from nine fixed values by two three-level strap inputs, so several copies can share one bus segment. SDA and SCL are sampled by the fast system clock through two-flop synchronizers. The target pulls SDA low through an output-enable line and never stretches the clock. It stays silent whenever the device's main input clock is reported stopped. The writable fields go to the rest of the device as twelve output-enable bits and a three-bit control field. Two status inputs are returned in register 0.

Top module: `smb_idx_regs`

## Requirements
- R1: Each strap input is coded 2'b00 low, 2'b01 mid, 2'b10 high (2'b11 behaves as high). With k = 3*level(strap_hi_i) + level(strap_lo_i), the target's address in 8-bit form (7-bit address shifted left by one) is element k of D8, DA, DE, C2, C4, C6, CA, CC, CE hex. The target ACKs that address and NACKs any other.
- R2: After a NACKed address the target drives nothing and ignores every byte until the next start condition.
- R3: Block write is: address+W, index N, count X, then data bytes. The target ACKs each of these. Data byte i goes to index N+i for i < X. Any data byte after the X-th is NACKed and stores nothing.
- R4: Block read is: address+W, index N, repeated start, address+R. The first byte returned is the count field (register 7 bits 4:0, upper bits 0). Data then follows from index N upward. Indices 9 and above read 00.
- R5: After count+1 data bytes, every further byte the host clocks reads FF (SDA released).
- R6: After reset: out_en_o = FFF, ctrl_o = 0, count field = 8. Register 5 reads {REV_ID, 4'b0001}, with the default REV_ID 0. Register 6 reads E7.
- R7: Writes to read-only or reserved bits are ACKed but change nothing. Reserved bits read 0.
- R8: While clk_run_i is low the target never drives SDA and no register changes.
- R9: The target changes SDA only while SCL is low. Exported fields change only while SCL is low.
- R10: Register layout:
  - Register 0: bits 7:6 = mode_stat_i, bits 3:1 = ctrl_o (RW), bit 0 = freq_stat_i, bits 5:4 reserved.
  - Register 1 = out_en_o[7:0] (RW).
  - Register 2: bits 3:0 = out_en_o[11:8] (RW).
  - Register 7: bits 4:0 = count (RW).
  - Registers 3, 4 and 8 are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_run_i | input | 1 | High while the main input clock runs |
| strap_hi_i | input | 2 | Upper address strap level |
| strap_lo_i | input | 2 | Lower address strap level |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_o | output | 1 | Data value when driven (always 0) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| mode_stat_i | input | 2 | Mode status returned in register 0 |
| freq_stat_i | input | 1 | Frequency status returned in register 0 |
| out_en_o | output | 12 | Per-output enable field |
| ctrl_o | output | 3 | Control field from register 0 |

## Verification
The bench walks all nine strap combinations plus the 2'b11 alias, and probes a near-miss address for each. A swapped table entry would ACK the wrong byte or NACK its own. It writes past the declared count and into read-only bytes. A design that kept storing after X bytes, or that let identification bytes change, shows the wrong export or readback. It shrinks the count field and reads past it and past index 8. An off-by-one in the length logic returns data where FF is due, or the reverse. With the main clock flagged stopped, an address that would otherwise match must get no ACK, and the exports must hold.

// File: rtl/smb_idx_pkg.sv
`timescale 1ns/1ps
package smb_idx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} link_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA} rx_ph_e;

  // three-level strap pair -> 7-bit address
  function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] h, l, k;
    logic [7:0] a8;
    h  = {2'b00, (hi == 2'b11) ? 2'b10 : hi};
    l  = {2'b00, (lo == 2'b11) ? 2'b10 : lo};
    k  = h * 4'd3 + l;
    case (k)
      4'd0:    a8 = 8'hD8;
      4'd1:    a8 = 8'hDA;
      4'd2:    a8 = 8'hDE;
      4'd3:    a8 = 8'hC2;
      4'd4:    a8 = 8'hC4;
      4'd5:    a8 = 8'hC6;
      4'd6:    a8 = 8'hCA;
      4'd7:    a8 = 8'hCC;
      default: a8 = 8'hCE;
    endcase
    return a8[7:1];
  endfunction
endpackage

// File: rtl/smb_idx_sync.sv
`timescale 1ns/1ps
module smb_idx_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= 2'b11;   // idle bus reads high
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/smb_idx_regfile.sv
`timescale 1ns/1ps
module smb_idx_regfile #(
  parameter logic [3:0] REV_ID  = 4'h0,
  parameter logic [3:0] VEN_ID  = 4'h1,
  parameter logic [7:0] DEV_ID  = 8'hE7,
  parameter logic [4:0] CNT_RST = 5'd8,
  parameter int         IDX_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       mode_stat_i,
  input  logic             freq_stat_i,
  output logic [7:0]       rd_data_o,
  output logic [4:0]       cnt_o,
  output logic [11:0]      out_en_o,
  output logic [2:0]       ctrl_o
);
  localparam int OE_LO_W = 8;
  localparam int OE_HI_W = 4;

  logic [2:0]         ctrl_q;
  logic [OE_LO_W-1:0] oe_lo_q;
  logic [OE_HI_W-1:0] oe_hi_q;
  logic [4:0]         cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      oe_lo_q <= '1;
      oe_hi_q <= '1;
      cnt_q   <= CNT_RST;
    end else if (wr_en_i) begin
      case (idx_i)
        IDX_W'(0): ctrl_q  <= wr_data_i[3:1];
        IDX_W'(1): oe_lo_q <= wr_data_i;
        IDX_W'(2): oe_hi_q <= wr_data_i[OE_HI_W-1:0];
        IDX_W'(7): cnt_q   <= wr_data_i[4:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_W'(0): rd_data_o = {mode_stat_i, 2'b00, ctrl_q, freq_stat_i};
      IDX_W'(1): rd_data_o = oe_lo_q;
      IDX_W'(2): rd_data_o = {4'b0000, oe_hi_q};
      IDX_W'(5): rd_data_o = {REV_ID, VEN_ID};
      IDX_W'(6): rd_data_o = DEV_ID;
      IDX_W'(7): rd_data_o = {3'b000, cnt_q};
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign cnt_o    = cnt_q;
  assign out_en_o = {oe_hi_q, oe_lo_q};
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/smb_idx_link.sv
`timescale 1ns/1ps
module smb_idx_link
  import smb_idx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic [6:0]       own_addr_i,
  input  logic [7:0]       rd_data_i,
  input  logic [4:0]       cnt_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       wr_data_o
);
  localparam int LEFT_W = 6;

  link_st_e          st;
  rx_ph_e            ph;
  logic              scl_q, sda_q;
  logic [3:0]        bcnt;
  logic [7:0]        sh, tx_sh;
  logic [IDX_W-1:0]  ptr;
  logic [7:0]        wr_left;
  logic [LEFT_W-1:0] rd_left;
  logic              go_tx, ack_rx, oe_q;

  logic start_ev, stop_ev, rise, fall, byte_done, rx_ack;
  assign start_ev  = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_ev   = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign rise      = scl_s_i & ~scl_q;
  assign fall      = ~scl_s_i & scl_q;
  assign byte_done = run_i && st == ST_RX && fall && bcnt == 4'd8;

  always_comb begin
    case (ph)
      PH_ADDR:  rx_ack = (sh[7:1] == own_addr_i);
      PH_WDATA: rx_ack = (wr_left != 8'd0);
      default:  rx_ack = 1'b1;
    endcase
  end

  assign wr_en_o   = byte_done && ph == PH_WDATA && wr_left != 8'd0;
  assign idx_o     = ptr;
  assign wr_data_o = sh;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bcnt    <= '0;
      sh      <= '0;
      tx_sh   <= '1;
      ptr     <= '0;
      wr_left <= '0;
      rd_left <= '0;
      go_tx   <= 1'b0;
      ack_rx  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
      oe_q  <= run_i & (st == ST_RX_ACK || (st == ST_TX && !tx_sh[7]));
      if (!run_i || stop_ev) begin
        st <= ST_IDLE;
      end else if (start_ev) begin
        st   <= ST_RX;
        ph   <= PH_ADDR;
        bcnt <= '0;
      end else begin
        case (st)
          ST_RX: begin
            if (rise && bcnt != 4'd8) begin
              sh   <= {sh[6:0], sda_s_i};
              bcnt <= bcnt + 4'd1;
            end else if (byte_done) begin
              st    <= rx_ack ? ST_RX_ACK : ST_IDLE;
              go_tx <= 1'b0;
              case (ph)
                PH_ADDR:  begin go_tx <= sh[0]; ph <= PH_INDEX; end
                PH_INDEX: begin ptr <= sh; ph <= PH_COUNT; end
                PH_COUNT: begin wr_left <= sh; ph <= PH_WDATA; end
                default: if (wr_left != 8'd0) begin
                  ptr     <= ptr + IDX_W'(1);
                  wr_left <= wr_left - 8'd1;
                end
              endcase
            end
          end
          ST_RX_ACK: if (fall) begin
            bcnt <= '0;
            if (go_tx) begin
              st      <= ST_TX;
              tx_sh   <= {3'b000, cnt_i};      // length byte leads
              rd_left <= {1'b0, cnt_i} + LEFT_W'(1);
            end else begin
              st <= ST_RX;
            end
          end
          ST_TX: if (fall) begin
            if (bcnt == 4'd7) st <= ST_TX_ACK;
            else begin
              tx_sh <= {tx_sh[6:0], 1'b1};
              bcnt  <= bcnt + 4'd1;
            end
          end
          ST_TX_ACK: begin
            if (rise) ack_rx <= ~sda_s_i;
            else if (fall) begin
              if (ack_rx) begin
                st   <= ST_TX;
                bcnt <= '0;
                if (rd_left != '0) begin
                  tx_sh   <= rd_data_i;
                  ptr     <= ptr + IDX_W'(1);
                  rd_left <= rd_left - LEFT_W'(1);
                end else begin
                  tx_sh <= 8'hFF;
                end
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_idx_regs.sv
`timescale 1ns/1ps
module smb_idx_regs
  import smb_idx_pkg::*;
#(
  parameter logic [3:0] REV_ID  = 4'h0,
  parameter logic [3:0] VEN_ID  = 4'h1,
  parameter logic [7:0] DEV_ID  = 8'hE7,
  parameter logic [4:0] CNT_RST = 5'd8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clk_run_i,
  input  logic [1:0]  strap_hi_i,
  input  logic [1:0]  strap_lo_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe_o,
  input  logic [1:0]  mode_stat_i,
  input  logic        freq_stat_i,
  output logic [11:0] out_en_o,
  output logic [2:0]  ctrl_o
);
  localparam int IDX_W = 8;

  logic             scl_s, sda_s, wr_en;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wr_data, rd_data;
  logic [4:0]       cnt;
  logic [6:0]       own_addr;

  assign own_addr = strap_addr(strap_hi_i, strap_lo_i);
  assign sda_o    = 1'b0;

  smb_idx_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  smb_idx_link #(.IDX_W(IDX_W)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (clk_run_i),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .own_addr_i(own_addr),
    .rd_data_i (rd_data),
    .cnt_i     (cnt),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .idx_o     (idx),
    .wr_data_o (wr_data)
  );

  smb_idx_regfile #(
    .REV_ID(REV_ID), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID),
    .CNT_RST(CNT_RST), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .idx_i      (idx),
    .wr_data_i  (wr_data),
    .mode_stat_i(mode_stat_i),
    .freq_stat_i(freq_stat_i),
    .rd_data_o  (rd_data),
    .cnt_o      (cnt),
    .out_en_o   (out_en_o),
    .ctrl_o     (ctrl_o)
  );
endmodule

// File: rtl/smb_idx_regs_chk.sv
`timescale 1ns/1ps
module smb_idx_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clk_run_i,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [11:0] out_en_o,
  input logic [2:0]  ctrl_o
);
  assert_quiet_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_run_i |=> !sda_oe_o);

  assert_export_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_run_i |=> ($stable(out_en_o) && $stable(ctrl_o)));

  assert_sda_setup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  assert_export_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o != $past(out_en_o) || ctrl_o != $past(ctrl_o)) |-> !scl_i);
endmodule

bind smb_idx_regs smb_idx_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_run_i(clk_run_i),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .out_en_o (out_en_o),
  .ctrl_o   (ctrl_o)
);

// File: tb/smb_idx_regs_tb.sv
`timescale 1ns/1ps
module smb_idx_regs_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, run, scl, host_sda, freq, dut_oe, dut_sda;
  logic [1:0] shi, slo, mode;
  logic [11:0] out_en;
  logic [2:0] ctrl;
  wire sda_line = host_sda & ~dut_oe;

  int nchk = 0, nfail = 0, glitches = 0;
  bit done = 0;
  logic [7:0] my_a8;

  smb_idx_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_run_i(run),
    .strap_hi_i(shi), .strap_lo_i(slo),
    .scl_i(scl), .sda_i(sda_line), .sda_o(dut_sda), .sda_oe_o(dut_oe),
    .mode_stat_i(mode), .freq_stat_i(freq),
    .out_en_o(out_en), .ctrl_o(ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    host_sda = 1; #80; scl = 1; #80; host_sda = 0; #80; scl = 0; #80;
  endtask
  task automatic bus_stop;
    host_sda = 0; #80; scl = 1; #80; host_sda = 1; #80;
  endtask
  task automatic wbit(input logic b);
    host_sda = b; #80; scl = 1; #160; scl = 0; #80;
  endtask
  task automatic rbit(output logic b);
    logic s0;
    host_sda = 1; #80; scl = 1; #40; s0 = sda_line; #80; b = sda_line;
    if (s0 !== b) glitches++;
    #40; scl = 0; #80;
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  // acks: [0] addr [1] index [2] count [3+i] data i
  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt,
                           input logic [31:0] d, input int n, output logic [6:0] acks);
    logic a;
    acks = '0;
    bus_start;
    wbyte(my_a8, a); acks[0] = a;
    wbyte(idx, a);   acks[1] = a;
    wbyte(cnt, a);   acks[2] = a;
    for (int i = 0; i < n; i++) begin
      wbyte(d[31-8*i -: 8], a);
      acks[3+i] = a;
    end
    bus_stop;
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n, output logic [7:0] cb,
                          output logic [127:0] data, output logic ok);
    logic a0, a1, a2;
    data = '0;
    bus_start;
    wbyte(my_a8, a0);
    wbyte(idx, a1);
    bus_start;
    wbyte(my_a8 | 8'h01, a2);
    ok = a0 & a1 & a2;
    rbyte(cb, n != 0);
    for (int i = 0; i < n; i++) rbyte(data[8*i +: 8], i != n - 1);
    bus_stop;
  endtask

  task automatic probe(input logic [7:0] a8, output logic ack);
    bus_start; wbyte(a8, ack); bus_stop;
  endtask

  function automatic logic [7:0] exp_addr(input int k);
    case (k)
      0: return 8'hD8; 1: return 8'hDA; 2: return 8'hDE;
      3: return 8'hC2; 4: return 8'hC4; 5: return 8'hC6;
      6: return 8'hCA; 7: return 8'hCC; default: return 8'hCE;
    endcase
  endfunction

  task automatic t_reset;
    logic [7:0] cb; logic [127:0] d; logic ok;
    chk("R6 out_en reset", 32'(out_en), 32'hFFF);
    chk("R6 ctrl reset", 32'(ctrl), 32'h0);
    blk_read(8'd0, 10, cb, d, ok);
    chk("R4 read acks", 32'(ok), 32'h1);
    chk("R4 R6 count byte", 32'(cb), 32'h08);
    chk("R10 reg0 status", 32'(d[7:0]), 32'h81);
    chk("R6 reg1..4", d[39:8], 32'h00000FFF);
    chk("R6 reg5 vendor", 32'(d[47:40]), 32'h01);
    chk("R6 reg6 device", 32'(d[55:48]), 32'hE7);
    chk("R6 reg7 count", 32'(d[63:56]), 32'h08);
    chk("R7 reg8 reserved", 32'(d[71:64]), 32'h00);
    chk("R5 past end", 32'(d[79:72]), 32'hFF);
  endtask

  task automatic t_write;
    logic [6:0] acks; logic [7:0] cb; logic [127:0] d; logic ok;
    blk_write(8'd1, 8'd2, 32'h5A3C0000, 3, acks);
    chk("R3 acks, extra byte nacked", 32'(acks[5:0]), 32'h1F);
    chk("R3 R7 out_en after write", 32'(out_en), 32'hC5A);
    blk_read(8'd1, 3, cb, d, ok);
    chk("R3 readback", 32'(d[23:0]), 32'h000C5A);
  endtask

  task automatic t_readonly;
    logic [6:0] acks; logic [7:0] cb; logic [127:0] d; logic ok;
    blk_write(8'd5, 8'd2, 32'hFF000000, 2, acks);
    chk("R7 ro write acked", 32'(acks[4:0]), 32'h1F);
    blk_write(8'd0, 8'd1, 32'hFF000000, 1, acks);
    chk("R10 ctrl_o", 32'(ctrl), 32'h7);
    blk_read(8'd5, 2, cb, d, ok);
    chk("R7 id unchanged", 32'(d[15:0]), 32'hE701);
    mode = 2'b01; freq = 1'b0;
    blk_read(8'd0, 1, cb, d, ok);
    chk("R10 R7 reg0 readback", 32'(d[7:0]), 32'h4E);
  endtask

  task automatic t_count;
    logic [6:0] acks; logic [7:0] cb; logic [127:0] d; logic ok;
    blk_write(8'd7, 8'd1, 32'hE2000000, 1, acks);
    blk_read(8'd1, 4, cb, d, ok);
    chk("R4 R7 count byte", 32'(cb), 32'h02);
    chk("R5 short read", d[31:0], 32'hFF000C5A);
    blk_read(8'd10, 4, cb, d, ok);
    chk("R4 beyond range", d[31:0], 32'hFF000000);
    blk_write(8'd7, 8'd1, 32'h08000000, 1, acks);
    chk("R3 count restored ack", 32'(acks[3]), 32'h1);
  endtask

  task automatic t_addr;
    logic a;
    for (int h = 0; h < 3; h++) begin
      for (int l = 0; l < 3; l++) begin
        shi = 2'(h); slo = 2'(l);
        probe(exp_addr(3*h + l), a);
        chk("R1 own address", 32'(a), 32'h1);
        probe(exp_addr(3*h + l) ^ 8'h02, a);
        chk("R1 other address", 32'(a), 32'h0);
      end
    end
    shi = 2'b11; slo = 2'b11;
    probe(8'hCE, a);
    chk("R1 strap 11 as high", 32'(a), 32'h1);
    shi = 2'b01; slo = 2'b10;
    bus_start;
    wbyte(8'hD8, a);
    chk("R2 mismatch nack", 32'(a), 32'h0);
    wbyte(my_a8, a);
    chk("R2 ignored until start", 32'(a), 32'h0);
    bus_stop;
    probe(my_a8, a);
    chk("R2 responds after start", 32'(a), 32'h1);
  endtask

  task automatic t_stopped;
    logic [6:0] acks; logic a;
    run = 1'b0;
    blk_write(8'd1, 8'd1, 32'h00000000, 1, acks);
    chk("R8 no ack while stopped", 32'(acks), 32'h0);
    chk("R8 exports held", 32'(out_en), 32'hC5A);
    run = 1'b1;
    probe(my_a8, a);
    chk("R8 resumes", 32'(a), 32'h1);
  endtask

  initial begin
    rst_n = 0; run = 1; scl = 1; host_sda = 1;
    shi = 2'b01; slo = 2'b10; mode = 2'b10; freq = 1'b1;
    my_a8 = 8'hC6;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write;
    t_readonly;
    t_count;
    t_addr;
    t_stopped;
    chk("R9 SDA stable while SCL high", 32'(glitches), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule